// File: doc/BRIEF.md
# Pilot-Normalized Dual-Tone Digital Downconverter

This block takes real samples from one pickup channel that is sampled directly, with no analog mixer ahead of the converter, and extracts two narrowband tones at once. One is the beam signal at the second RF harmonic. The other is a pilot tone injected a few tens of kHz above it, for example 101.26 MHz and 101.31 MHz. Each tone has its own numerically controlled oscillator and mixer, producing I and Q. Each of the four I/Q paths has a three-stage CIC decimator, and each tone has a 16-step CORDIC magnitude unit. The beam magnitude is then divided by the pilot magnitude. Gain and temperature drift in the analog chain affect both tones equally, so they cancel in the quotient. The fixed CORDIC gain of about 1.6468 also cancels. One instance serves one electrode; a position monitor places one per pickup.

A control state machine sequences the result path. Its states are S_IDLE (no run started), S_WAIT (collecting decimated samples and dropping the warm-up ones), S_MAG (both magnitude units running), S_DIV (divider running) and S_EMIT (result just presented).

The transitions are:
- `start` from any state goes to S_WAIT.
- S_WAIT goes to S_MAG on a decimated sample after the warm-up is over.
- S_MAG goes to S_DIV when both magnitudes are done.
- S_DIV goes to S_EMIT when the quotient is done.
- S_EMIT always goes back to S_WAIT.

A `start` pulse clears the oscillators, filters and warm-up count. It also latches the decimation setting. The phase increments are taken at `start` and again at every decimation boundary. The user must keep the decimation ratio times the sample spacing at 40 clock cycles or more. A decimated sample that arrives while the result path is busy is dropped.

Top module: `dual_tone_ddc`

## Requirements
- R1: After reset, `out_valid`, `beam_mag`, `pilot_mag`, `ratio` and `pilot_zero` are all zero.
- R2: With `pilot_inc` = 0 (tuned to DC), a constant input level A gives `pilot_mag` = 1.6468·|A| within 1% + 4 LSB, for either sign of A.
- R3: With `beam_inc` = 0x8000_0000 (half a turn per sample), an input component whose sign alternates every sample with amplitude B gives `beam_mag` = 1.6468·|B| within 1% + 4 LSB. A constant input with no alternating part gives `beam_mag` below 8.
- R4: When 0 < `beam_mag` < `pilot_mag`, `ratio` = floor(`beam_mag`·65536 / `pilot_mag`). This makes `ratio` an unsigned fraction with 16 fractional bits.
- R5: When `beam_mag` ≥ `pilot_mag` > 0, `ratio` is 0xFFFF and `pilot_zero` is 0.
- R6: When `pilot_mag` is 0, `ratio` is 0xFFFF and `pilot_zero` is 1.
- R7: `out_valid` is high for exactly one cycle per result. All three outputs come from the same decimation interval. No result appears before the first `start`. After a `start`, the first three decimated samples are discarded, so the first result follows the fourth decimated sample.
- R8: The decimation ratio is 2^`dec_log2`, for `dec_log2` from 3 to 10, latched at `start`. The output scale does not depend on the ratio: the results of R2 to R4 hold at ratios 8, 64 and 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run: clears the pipeline and latches settings |
| smp_valid | input | 1 | Qualifies `smp` |
| smp | input | 12 | Signed ADC sample |
| beam_inc | input | 32 | Phase increment per sample, beam oscillator |
| pilot_inc | input | 32 | Phase increment per sample, pilot oscillator |
| dec_log2 | input | 4 | Base-2 logarithm of the decimation ratio |
| beam_mag | output | 26 | Beam tone magnitude, including the CORDIC gain |
| pilot_mag | output | 26 | Pilot tone magnitude, including the CORDIC gain |
| ratio | output | 16 | beam/pilot as an unsigned fraction with 16 fractional bits |
| pilot_zero | output | 1 | Pilot magnitude of zero in this result |
| out_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench feeds a constant level plus a part that flips sign every sample. This lets each tuned channel pick out exactly one part, and a design with swapped channels or a broken quadrant fold shows the wrong magnitude. Negative levels exercise the CORDIC pre-rotation: a design that skips it reports a small or wrong magnitude. The divider is driven to three edges. Beam above pilot must saturate without the error flag, an all-zero input must raise the flag, and a design that ran the loop anyway would return a wrapped quotient. Warm-up and pulse timing are checked at ratios 8, 64 and 1024. Results taken too early, or a shift that ignores the ratio, show up as a misplaced first pulse or a scaled magnitude.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_MAG,
        S_DIV,
        S_EMIT
    } ddc_state_t;

    localparam int WARM_OUTS = 3;
endpackage

// File: rtl/ddc_nco_mix.sv
module ddc_nco_mix #(
    parameter int ADC_W  = 12,
    parameter int PH_W   = 32,
    parameter int LUT_AW = 10,
    parameter int LUT_W  = 16,
    parameter int MIX_W  = ADC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load,
    input  logic [PH_W-1:0]         inc_in,
    input  logic                    smp_valid,
    input  logic signed [ADC_W-1:0] smp,
    output logic signed [MIX_W-1:0] mix_i,
    output logic signed [MIX_W-1:0] mix_q
);
    localparam int PW = LUT_AW + 2;
    localparam int PRW = ADC_W + LUT_W;

    logic signed [LUT_W-1:0] rom [1 << LUT_AW];

    // quarter-wave table sampled at half-step offsets so the folds are exact mirrors
    initial begin
        for (int a = 0; a < (1 << LUT_AW); a++) begin
            rom[a] = LUT_W'($rtoi($sin((real'(a) + 0.5) * 3.14159265358979 /
                     real'(2 << LUT_AW)) * real'((1 << (LUT_W-1)) - 1) + 0.5));
        end
    end

    function automatic logic signed [LUT_W-1:0] qsin(input logic [PW-1:0] p);
        logic [LUT_AW-1:0] ad;
        ad = p[PW-2] ? ~p[LUT_AW-1:0] : p[LUT_AW-1:0];
        return p[PW-1] ? -rom[ad] : rom[ad];
    endfunction

    logic [PH_W-1:0] phase, inc_act;
    logic [PW-1:0] ph;
    logic signed [LUT_W-1:0] cosv, sinv;
    logic signed [PRW-1:0] pi, pq;

    assign ph   = phase[PH_W-1 -: PW];
    assign cosv = qsin(ph + PW'(1 << LUT_AW));
    assign sinv = qsin(ph);
    assign pi   = PRW'(smp) * PRW'(cosv);
    assign pq   = PRW'(smp) * PRW'(sinv);

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_act <= '0;
        end else if (load) begin
            inc_act <= inc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
            mix_i <= '0;
            mix_q <= '0;
        end else if (smp_valid) begin
            phase <= phase + inc_act;
            mix_i <= MIX_W'(pi >>> (LUT_W-1));
            mix_q <= MIX_W'(pq >>> (LUT_W-1));
        end
    end
endmodule

// File: rtl/ddc_cic3.sv
module ddc_cic3 #(
    parameter int IN_W  = 13,
    parameter int ACC_W = 43,
    parameter int OUT_W = 24,
    parameter int SH_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  din,
    input  logic                    dec_stb,
    input  logic [SH_W-1:0]         sh,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [ACC_W-1:0] i1, i2, i3, d1, d2, d3, c1, c2, c3;

    always_comb begin
        c1 = i3 - d1;
        c2 = c1 - d2;
        c3 = c2 - d3;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            i1 <= '0; i2 <= '0; i3 <= '0;
            d1 <= '0; d2 <= '0; d3 <= '0;
            dout <= '0;
        end else begin
            if (in_valid) begin
                i1 <= i1 + ACC_W'(din);
                i2 <= i2 + i1;
                i3 <= i3 + i2;
            end
            if (dec_stb) begin
                d1 <= i3;
                d2 <= c1;
                d3 <= c2;
                dout <= OUT_W'(c3 >>> sh);
            end
        end
    end
endmodule

// File: rtl/ddc_cordic_mag.sv
module ddc_cordic_mag #(
    parameter int IN_W  = 24,
    parameter int ITER  = 16,
    parameter int GB    = 4,
    parameter int MAG_W = IN_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic signed [IN_W-1:0] xin,
    input  logic signed [IN_W-1:0] yin,
    output logic [MAG_W-1:0]       mag,
    output logic                   done
);
    localparam int CW = MAG_W + GB;
    localparam int IW = $clog2(ITER);

    logic signed [CW-1:0] x, y;
    logic [IW-1:0] it;
    logic busy;

    assign mag = MAG_W'(x >>> GB);

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0; y <= '0; it <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                // rotate into the right half-plane first; the magnitude is unchanged
                x <= (xin < 0) ? -(CW'(xin) <<< GB) : (CW'(xin) <<< GB);
                y <= (xin < 0) ? -(CW'(yin) <<< GB) : (CW'(yin) <<< GB);
                it <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (y >= 0) begin
                    x <= x + (y >>> it);
                    y <= y - (x >>> it);
                end else begin
                    x <= x - (y >>> it);
                    y <= y + (x >>> it);
                end
                it <= it + 1'b1;
                if (it == IW'(ITER-1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_mag_nonneg_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !x[CW-1]);
endmodule

// File: rtl/ddc_ratio_div.sv
module ddc_ratio_div #(
    parameter int MW = 26,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [MW-1:0] num,
    input  logic [MW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          zero_err,
    output logic          done
);
    localparam int CNT_W = $clog2(QW);

    logic [MW:0] rem, r2;
    logic [MW-1:0] dv;
    logic [CNT_W-1:0] cnt;
    logic busy;

    assign r2 = {rem[MW-1:0], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0; dv <= '0; cnt <= '0; busy <= 1'b0;
            quo <= '0; zero_err <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                zero_err <= (den == '0);
                if (den == '0 || num >= den) begin
                    quo  <= '1;
                    done <= 1'b1;
                    busy <= 1'b0;
                end else begin
                    rem  <= {1'b0, num};
                    dv   <= den;
                    cnt  <= '0;
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (r2 >= {1'b0, dv}) begin
                    rem <= r2 - {1'b0, dv};
                    quo <= {quo[QW-2:0], 1'b1};
                end else begin
                    rem <= r2;
                    quo <= {quo[QW-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(QW-1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_tone_ddc.sv
module dual_tone_ddc
    import ddc_pkg::*;
#(
    parameter int ADC_W   = 12,
    parameter int PH_W    = 32,
    parameter int DLOG_W  = 4,
    parameter int MIN_LOG = 3,
    parameter int MAX_LOG = 10,
    parameter int OUT_W   = 24,
    parameter int ITER    = 16,
    parameter int QW      = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    smp_valid,
    input  logic signed [ADC_W-1:0] smp,
    input  logic [PH_W-1:0]         beam_inc,
    input  logic [PH_W-1:0]         pilot_inc,
    input  logic [DLOG_W-1:0]       dec_log2,
    output logic [OUT_W+1:0]        beam_mag,
    output logic [OUT_W+1:0]        pilot_mag,
    output logic [QW-1:0]           ratio,
    output logic                    pilot_zero,
    output logic                    out_valid
);
    localparam int MIX_W  = ADC_W + 1;
    localparam int ACC_W  = MIX_W + 3 * MAX_LOG;
    localparam int MAG_W  = OUT_W + 2;
    localparam int SH_W   = DLOG_W + 2;
    localparam int WARM_W = $clog2(WARM_OUTS + 1);

    ddc_state_t state, nxt;
    logic [DLOG_W-1:0] dec_act;
    logic [MAX_LOG-1:0] cnt, rlim;
    logic [SH_W-1:0] sh;
    logic [WARM_W-1:0] warm;
    logic mix_valid, dec_stb, cic_valid, mag_go, div_go, div_done, div_err;
    logic [QW-1:0] quo;
    logic [1:0] cdone;
    logic signed [MIX_W-1:0] mi [2];
    logic signed [MIX_W-1:0] mq [2];
    logic signed [OUT_W-1:0] ci [2];
    logic signed [OUT_W-1:0] cq [2];
    logic [MAG_W-1:0] mag [2];

    assign rlim    = MAX_LOG'((1 << dec_act) - 1);
    assign sh      = SH_W'(3 * dec_act);
    assign dec_stb = mix_valid && (cnt == rlim);

    // channel 0 is tuned to the beam harmonic, channel 1 to the pilot
    for (genvar c = 0; c < 2; c++) begin : g_tone
        ddc_nco_mix #(.ADC_W(ADC_W), .PH_W(PH_W), .MIX_W(MIX_W)) u_nco (
            .clk(clk), .rst(rst), .clr(start), .load(start || dec_stb),
            .inc_in(c == 0 ? beam_inc : pilot_inc), .smp_valid(smp_valid),
            .smp(smp), .mix_i(mi[c]), .mix_q(mq[c]));
        ddc_cic3 #(.IN_W(MIX_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_cic_i (
            .clk(clk), .rst(rst), .clr(start), .in_valid(mix_valid), .din(mi[c]),
            .dec_stb(dec_stb), .sh(sh), .dout(ci[c]));
        ddc_cic3 #(.IN_W(MIX_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_cic_q (
            .clk(clk), .rst(rst), .clr(start), .in_valid(mix_valid), .din(mq[c]),
            .dec_stb(dec_stb), .sh(sh), .dout(cq[c]));
        ddc_cordic_mag #(.IN_W(OUT_W), .ITER(ITER), .MAG_W(MAG_W)) u_mag (
            .clk(clk), .rst(rst), .go(mag_go), .xin(ci[c]), .yin(cq[c]),
            .mag(mag[c]), .done(cdone[c]));
    end

    ddc_ratio_div #(.MW(MAG_W), .QW(QW)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(mag[0]), .den(mag[1]),
        .quo(quo), .zero_err(div_err), .done(div_done));

    assign mag_go = !start && (state == S_WAIT) && cic_valid && (warm == WARM_W'(WARM_OUTS));
    assign div_go = !start && (state == S_MAG) && (&cdone);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_act <= DLOG_W'(MIN_LOG);
            cnt <= '0; mix_valid <= 1'b0; cic_valid <= 1'b0;
        end else begin
            if (start) dec_act <= dec_log2;
            mix_valid <= smp_valid && !start;
            cic_valid <= dec_stb && !start;
            if (start) cnt <= '0;
            else if (mix_valid) cnt <= (cnt == rlim) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = S_WAIT;
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_WAIT: if (mag_go) nxt = S_MAG;
                S_MAG:  if (&cdone) nxt = S_DIV;
                S_DIV:  if (div_done) nxt = S_EMIT;
                S_EMIT: nxt = S_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0; out_valid <= 1'b0; beam_mag <= '0;
            pilot_mag <= '0; ratio <= '0; pilot_zero <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                warm <= '0;
            end else if (state == S_WAIT && cic_valid && warm != WARM_W'(WARM_OUTS)) begin
                warm <= warm + 1'b1;
            end
            if (!start && state == S_DIV && div_done) begin
                beam_mag   <= mag[0];
                pilot_mag  <= mag[1];
                ratio      <= quo;
                pilot_zero <= div_err;
                out_valid  <= 1'b1;
            end
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    assert_zero_pilot_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pilot_mag == '0) |-> (pilot_zero && ratio == '1));
    assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pilot_mag != '0 && beam_mag >= pilot_mag) |-> (ratio == '1 && !pilot_zero));
    assert_ratio_low_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pilot_mag != '0 && beam_mag < pilot_mag) |->
        ((MAG_W+QW)'(ratio) * (MAG_W+QW)'(pilot_mag) <= {beam_mag, {QW{1'b0}}}));
    assert_ratio_high_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pilot_mag != '0 && beam_mag < pilot_mag) |->
        (((MAG_W+QW)'(ratio) + 1) * (MAG_W+QW)'(pilot_mag) > {beam_mag, {QW{1'b0}}}));
    assert_dec_range_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> (dec_log2 >= DLOG_W'(MIN_LOG) && dec_log2 <= DLOG_W'(MAX_LOG)));
endmodule

// File: tb/dual_tone_ddc_tb_top.sv
module dual_tone_ddc_tb_top;
    localparam real KG = 1.646760258;

    logic clk = 1'b0;
    logic rst, start, smp_valid;
    logic signed [11:0] smp;
    logic [31:0] beam_inc, pilot_inc;
    logic [3:0] dec_log2;
    logic [25:0] beam_mag, pilot_mag;
    logic [15:0] ratio;
    logic pilot_zero, out_valid;

    int total = 0, bad = 0;
    int nv, first_idx, dbl;
    longint g_beam, g_pilot, g_ratio, g_err;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_tone_ddc dut_i (
        .clk(clk), .rst(rst), .start(start), .smp_valid(smp_valid), .smp(smp),
        .beam_inc(beam_inc), .pilot_inc(pilot_inc), .dec_log2(dec_log2),
        .beam_mag(beam_mag), .pilot_mag(pilot_mag), .ratio(ratio),
        .pilot_zero(pilot_zero), .out_valid(out_valid));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what,
                            input longint act, input real exp, input real tol);
        real d;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        chk(d <= tol, req, what, act, longint'(exp));
    endtask

    // constant level a0 plus a part of amplitude a1 that flips sign every sample
    task automatic run_case(input int a0, input int a1, input int k, input int sp, input int nout);
        int idx, cyc, lim;
        bit prevv;
        beam_inc = 32'h8000_0000;
        pilot_inc = 32'h0;
        dec_log2 = 4'(k);
        @(negedge clk);
        start = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        idx = 0; cyc = 0; nv = 0; first_idx = -1; dbl = 0; prevv = 1'b0;
        lim = (nout + 6) * (1 << k) * sp + 400;
        while (nv < nout && cyc < lim) begin
            if (out_valid) begin
                nv++;
                if (first_idx < 0) first_idx = idx;
                if (prevv) dbl = 1;
                g_beam = longint'(beam_mag);
                g_pilot = longint'(pilot_mag);
                g_ratio = longint'(ratio);
                g_err = longint'(pilot_zero);
            end
            prevv = out_valid;
            smp_valid = (cyc % sp) == 0;
            if (smp_valid) begin
                smp = 12'((idx % 2 == 0) ? a0 + a1 : a0 - a1);
                idx++;
            end
            cyc++;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk(nv == nout, "R7", "result count", nv, nout);
        chk(dbl == 0, "R7", "single-cycle pulse", dbl, 0);
    endtask

    task automatic check_tones(input string req, input int a0, input int a1);
        real ep, eb;
        ep = KG * real'(a0 < 0 ? -a0 : a0);
        eb = KG * real'(a1 < 0 ? -a1 : a1);
        chk_near(req, "pilot_mag", g_pilot, ep, ep / 100.0 + 4.0);
        chk_near(req, "beam_mag", g_beam, eb, eb / 100.0 + 4.0);
        chk_near("R4", "ratio", g_ratio, eb * 65536.0 / ep, eb * 65536.0 / ep / 200.0 + 8.0);
    endtask

    task automatic t_reset_state;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(beam_mag == '0 && pilot_mag == '0, "R1", "mags after reset", beam_mag + pilot_mag, 0);
        chk(ratio == '0 && pilot_zero == 1'b0, "R1", "ratio/flag after reset", ratio + pilot_zero, 0);
    endtask

    task automatic t_no_start;
        int cntv = 0;
        for (int i = 0; i < 300; i++) begin
            smp_valid = 1'b1;
            smp = 12'((i % 2 == 0) ? 700 : -100);
            @(negedge clk);
            if (out_valid) cntv++;
        end
        smp_valid = 1'b0;
        chk(cntv == 0, "R7", "no result before first start", cntv, 0);
    endtask

    task automatic t_basic;
        run_case(1000, 500, 6, 1, 3);
        check_tones("R2", 1000, 500);
        chk(first_idx >= 4 * 64 && first_idx < 5 * 64, "R7", "first result sample index", first_idx, 4 * 64);
        chk(g_err == 0, "R6", "flag clear with live pilot", g_err, 0);
    endtask

    task automatic t_negative;
        run_case(-900, -450, 6, 1, 3);
        check_tones("R2", -900, -450);
    endtask

    task automatic t_saturate;
        run_case(300, 600, 6, 1, 3);
        chk(g_ratio == 16'hFFFF, "R5", "ratio when beam exceeds pilot", g_ratio, 16'hFFFF);
        chk(g_err == 0, "R5", "no flag on saturation", g_err, 0);
    endtask

    task automatic t_zero_pilot;
        run_case(0, 0, 6, 1, 3);
        chk(g_pilot == 0, "R6", "pilot_mag for silent input", g_pilot, 0);
        chk(g_ratio == 16'hFFFF, "R6", "ratio for zero pilot", g_ratio, 16'hFFFF);
        chk(g_err == 1, "R6", "zero-pilot flag", g_err, 1);
    endtask

    task automatic t_beam_reject;
        run_case(800, 0, 6, 1, 3);
        chk(g_beam < 8, "R3", "beam_mag with no beam tone", g_beam, 0);
        chk(g_ratio < 400, "R3", "ratio with no beam tone", g_ratio, 0);
    endtask

    task automatic t_min_ratio;
        run_case(1200, 300, 3, 8, 3);
        check_tones("R8", 1200, 300);
        chk(first_idx >= 4 * 8 && first_idx < 5 * 8, "R8", "first result at ratio 8", first_idx, 32);
    endtask

    task automatic t_max_ratio;
        run_case(1000, 250, 10, 1, 2);
        check_tones("R8", 1000, 250);
        chk(first_idx >= 4 * 1024 && first_idx < 5 * 1024, "R8", "first result at ratio 1024", first_idx, 4096);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; smp_valid = 1'b0; smp = '0;
        beam_inc = '0; pilot_inc = '0; dec_log2 = 4'd6;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_no_start();
        t_basic();
        t_negative();
        t_saturate();
        t_zero_pilot();
        t_beam_reject();
        t_min_ratio();
        t_max_ratio();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule